// File: doc/BRIEF.md
# Page Entry Permission Checker

This block examines one page-translation entry at a time and reports whether an access through it is allowed. A request brings the 64-bit entry, the table level it was read from, the kind of access (read, write or instruction fetch), the current privilege level and four mode flags: wide-entry (PAE) mode, long mode, no-execute enable and page-size extension enable. The response reports four things. It gives a fault flag with a 3-bit cause. It says whether the entry ends the walk, and if so the page size and the frame base with its offset bits cleared. It gives a 3-bit caching attribute index. It also returns the entry with its Accessed and Dirty marks applied and a flag that says whether that entry must be written back to memory.

The unit holds a single output register. A request is taken on a valid/ready handshake. Its result appears on the next clock and stays there until the consumer takes it. A page walker feeds each level's entry through the unit in turn and combines the permissions from each pass. The unit keeps no state between requests.

Top module: `pte_check_unit`

## Requirements
- R1: When entry bit 0 (present) is 0 the cause is 1 (not present). All other entry bits are ignored for the fault decision, the returned entry equals the input and writeback-needed is 0.
- R2: When entry bit 1 (writable) is 0, a write (access code 1) faults with cause 4. Reads (code 0) and fetches (code 2) are not affected.
- R3: When entry bit 2 (user) is 0, a request at privilege level 3 faults with cause 3. Levels 0 to 2 are not affected.
- R4: On any access without a fault, bit 5 (Accessed) is set in the returned entry. Writeback-needed is 1 only when the access has no fault and bit 5 or bit 6 actually changed. The unit never clears bit 5 or bit 6.
- R5: On a write without a fault, bit 6 (Dirty) is set only when the entry ends the walk. An entry that points to a lower table keeps bit 6 unchanged.
- R6: Bit 63 matters only in wide-entry mode. There, if no-execute enable is 0 and bit 63 is 1, the cause is 2. If no-execute enable is 1 and bit 63 is 1, a fetch gets cause 5. In 32-bit mode, bit 63 has no effect.
- R7: Level code 0 is the lowest table and always ends the walk with size code 0 (4 KB). With bit 7 set, level 1 ends the walk with size code 1 (2 MB) in wide-entry mode or size code 2 (4 MB) otherwise. Level 2 with bit 7 set ends the walk with size code 3 (1 GB) only in long mode. Every other case does not end the walk and reports size code 0.
- R8: The frame base is the entry with these offset bits cleared: bits 11..0 for 4 KB, 20..0 for 2 MB, 21..0 for 4 MB and 29..0 for 1 GB. Only bits below PA_W (default 52) are kept in wide-entry mode and only bits 31..0 in 32-bit mode.
- R9: The attribute index is {pat, bit 4, bit 3}. Here pat is bit 7 at level 0, bit 12 for a large page that ends the walk, and 0 for a pointer to a table.
- R10: Strict checking applies in long mode, or in wide-entry mode with size extension enabled. Under strict checking, a set bit in 62..PA_W gives cause 2. So does a set bit from 13 up to the top offset bit of a large page that ends the walk. Without strict checking these bits are ignored.
- R11: When several faults apply, the cause reported is the first in this order: not present (1), reserved (2), privilege (3), write (4), execute (5). Cause 0 means no fault, and the fault flag equals (cause != 0).
- R12: A request is accepted when req_valid and req_ready are both 1. req_ready is 1 whenever no result is pending or the pending result is being accepted in the same cycle. The result is valid on the cycle after acceptance and holds steady while rsp_ready is 0.
- R13: After reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_entry | input | 64 | Page-translation entry under check |
| req_level | input | 2 | Table level: 0 lowest, 1 directory, 2 directory pointer, 3 top |
| req_access | input | 2 | 0 read, 1 write, 2 fetch |
| req_cpl | input | 2 | Current privilege level |
| req_pae | input | 1 | Wide-entry mode |
| req_long | input | 1 | Long mode active |
| req_nxe | input | 1 | No-execute enable |
| req_pse | input | 1 | Page-size extension enable |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Access faults |
| rsp_cause | output | 3 | Fault cause code |
| rsp_leaf | output | 1 | Entry ends the walk |
| rsp_size | output | 2 | Page size code |
| rsp_base | output | 64 | Aligned frame base |
| rsp_attr | output | 3 | Caching attribute index |
| rsp_entry | output | 64 | Entry with Accessed/Dirty applied |
| rsp_wb | output | 1 | Updated entry must be written back |

## Verification
Each result is registered once, so a wrong decision in the fault chain, the size decode or the mark update shows on the cycle right after the request is taken. It appears as a wrong cause, size, base or returned entry. A fault on rsp_cause does not always show up in the returned entry. A missing or spurious Accessed or Dirty mark, however, shows up at once through rsp_wb and the returned entry. Broken response storage cannot be seen while rsp_ready stays high. The response must therefore be stalled for several cycles and a new request queued behind it, so that a lost or overwritten result becomes visible.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] PG_4K = 2'd0;
  localparam logic [1:0] PG_2M = 2'd1;
  localparam logic [1:0] PG_4M = 2'd2;
  localparam logic [1:0] PG_1G = 2'd3;

  localparam logic [2:0] FLT_NONE    = 3'd0;
  localparam logic [2:0] FLT_NOTPRES = 3'd1;
  localparam logic [2:0] FLT_RSVD    = 3'd2;
  localparam logic [2:0] FLT_PRIV    = 3'd3;
  localparam logic [2:0] FLT_WRITE   = 3'd4;
  localparam logic [2:0] FLT_EXEC    = 3'd5;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USER  = 2;
  localparam int B_PWT   = 3;
  localparam int B_PCD   = 4;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_SIZE  = 7;
  localparam int B_PATLG = 12;
  localparam int B_NX    = 63;

  // Number of page-offset bits for a size code.
  function automatic int offset_bits(input logic [1:0] sz);
    case (sz)
      PG_2M:   offset_bits = 21;
      PG_4M:   offset_bits = 22;
      PG_1G:   offset_bits = 30;
      default: offset_bits = 12;
    endcase
  endfunction

  // Bits of an entry that form the frame base.
  function automatic logic [63:0] frame_mask(input logic [1:0] sz, input logic wide,
                                             input int pa_w);
    logic [63:0] lo_clr;
    logic [63:0] hi_keep;
    int w;
    w       = wide ? pa_w : 32;
    lo_clr  = ~((64'd1 << offset_bits(sz)) - 64'd1);
    hi_keep = (64'd1 << w) - 64'd1;
    frame_mask = lo_clr & hi_keep;
  endfunction

  // Bits that must be zero under strict checking.
  function automatic logic [63:0] rsvd_mask(input logic [1:0] sz, input logic leaf,
                                            input int pa_w);
    logic [63:0] m;
    int ob;
    ob = offset_bits(sz);
    for (int i = 0; i < 64; i++) begin
      m[i] = ((i >= pa_w) && (i <= 62)) ||
             (leaf && (sz != PG_4K) && (i >= 13) && (i < ob));
    end
    rsvd_mask = m;
  endfunction

endpackage

// File: rtl/pte_size_decode.sv
module pte_size_decode
  import pte_chk_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] entry,
  input  logic [1:0]  level,
  input  logic        wide,
  input  logic        lmode,
  output logic [1:0]  size,
  output logic        leaf,
  output logic [63:0] base,
  output logic [2:0]  attr
);

  logic large_dir;
  logic large_ptr;
  logic pat_bit;

  assign large_dir = entry[B_SIZE] && (level == 2'd1);
  assign large_ptr = entry[B_SIZE] && (level == 2'd2) && lmode;

  always_comb begin
    if (large_ptr)      size = PG_1G;
    else if (large_dir) size = wide ? PG_2M : PG_4M;
    else                size = PG_4K;
  end

  assign leaf = (level == 2'd0) || large_dir || large_ptr;

  always_comb begin
    if (level == 2'd0)               pat_bit = entry[B_SIZE];
    else if (large_dir || large_ptr) pat_bit = entry[B_PATLG];
    else                             pat_bit = 1'b0;
  end

  assign attr = {pat_bit, entry[B_PCD], entry[B_PWT]};
  assign base = entry & frame_mask(size, wide, PA_W);

  // R8: base never holds a bit the entry lacks, and 1 GB bases are aligned
  p_base_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((base & ~entry) == 64'd0));
  p_gig_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (size == PG_1G) |-> (base[29:0] == 30'd0));
  // R7: a non-lowest level without the size bit never ends the walk
  p_table_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((level != 2'd0) && !entry[B_SIZE]) |-> (!leaf && size == PG_4K));

endmodule

// File: rtl/pte_fault_eval.sv
module pte_fault_eval
  import pte_chk_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] entry,
  input  logic [1:0]  size,
  input  logic        leaf,
  input  logic [1:0]  access,
  input  logic [1:0]  cpl,
  input  logic        wide,
  input  logic        lmode,
  input  logic        nxe,
  input  logic        pse,
  output logic [2:0]  cause
);

  logic strict;
  logic ev_np, ev_rsv, ev_priv, ev_wr, ev_nx;

  assign strict  = lmode || (wide && pse);
  assign ev_np   = !entry[B_PRES];
  assign ev_rsv  = (wide && !nxe && entry[B_NX]) ||
                   (strict && |(entry & rsvd_mask(size, leaf, PA_W)));
  assign ev_priv = (cpl == 2'd3) && !entry[B_USER];
  assign ev_wr   = (access == ACC_WRITE) && !entry[B_WR];
  assign ev_nx   = (access == ACC_FETCH) && wide && nxe && entry[B_NX];

  always_comb begin
    if (ev_np)        cause = FLT_NOTPRES;
    else if (ev_rsv)  cause = FLT_RSVD;
    else if (ev_priv) cause = FLT_PRIV;
    else if (ev_wr)   cause = FLT_WRITE;
    else if (ev_nx)   cause = FLT_EXEC;
    else              cause = FLT_NONE;
  end

  // R11: a lower-priority cause is never reported over a higher one
  p_np_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_np |-> (cause == FLT_NOTPRES));
  p_rsv_over_priv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_np && ev_rsv) |-> (cause == FLT_RSVD));
  // R3: privilege levels 0..2 never get a privilege fault
  p_sup_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl != 2'd3) |-> (cause != FLT_PRIV));
  // R6: 32-bit mode never reports an execute fault
  p_no_nx_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (cause != FLT_EXEC));

endmodule

// File: rtl/pte_ad_update.sv
module pte_ad_update
  import pte_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] entry,
  input  logic        leaf,
  input  logic [1:0]  access,
  input  logic        fault,
  output logic [63:0] entry_out,
  output logic        wb
);

  logic set_a;
  logic set_d;

  assign set_a = !fault && !entry[B_ACC];
  assign set_d = !fault && leaf && (access == ACC_WRITE) && !entry[B_DIRTY];

  always_comb begin
    entry_out = entry;
    if (set_a) entry_out[B_ACC]   = 1'b1;
    if (set_d) entry_out[B_DIRTY] = 1'b1;
  end

  assign wb = set_a || set_d;

  // R4: marks are sticky
  p_acc_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    entry[B_ACC] |-> entry_out[B_ACC]);
  p_dirty_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    entry[B_DIRTY] |-> entry_out[B_DIRTY]);
  // R5: a table pointer never gains a Dirty mark
  p_no_dirty_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !leaf |-> (entry_out[B_DIRTY] == entry[B_DIRTY]));
  // R1: a faulting access leaves the entry untouched
  p_fault_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (entry_out == entry && !wb));

endmodule

// File: rtl/pte_check_unit.sv
module pte_check_unit
  import pte_chk_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_entry,
  input  logic [1:0]  req_level,
  input  logic [1:0]  req_access,
  input  logic [1:0]  req_cpl,
  input  logic        req_pae,
  input  logic        req_long,
  input  logic        req_nxe,
  input  logic        req_pse,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [2:0]  rsp_cause,
  output logic        rsp_leaf,
  output logic [1:0]  rsp_size,
  output logic [63:0] rsp_base,
  output logic [2:0]  rsp_attr,
  output logic [63:0] rsp_entry,
  output logic        rsp_wb
);

  logic [1:0]  c_size;
  logic        c_leaf;
  logic [63:0] c_base;
  logic [2:0]  c_attr;
  logic [2:0]  c_cause;
  logic        c_fault;
  logic [63:0] c_entry;
  logic        c_wb;
  logic        accept;

  pte_size_decode #(.PA_W(PA_W)) u_size (
    .clk   (clk),
    .rst_n (rst_n),
    .entry (req_entry),
    .level (req_level),
    .wide  (req_pae),
    .lmode (req_long),
    .size  (c_size),
    .leaf  (c_leaf),
    .base  (c_base),
    .attr  (c_attr)
  );

  pte_fault_eval #(.PA_W(PA_W)) u_fault (
    .clk    (clk),
    .rst_n  (rst_n),
    .entry  (req_entry),
    .size   (c_size),
    .leaf   (c_leaf),
    .access (req_access),
    .cpl    (req_cpl),
    .wide   (req_pae),
    .lmode  (req_long),
    .nxe    (req_nxe),
    .pse    (req_pse),
    .cause  (c_cause)
  );

  assign c_fault = (c_cause != FLT_NONE);

  pte_ad_update u_mark (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry     (req_entry),
    .leaf      (c_leaf),
    .access    (req_access),
    .fault     (c_fault),
    .entry_out (c_entry),
    .wb        (c_wb)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= FLT_NONE;
      rsp_leaf  <= 1'b0;
      rsp_size  <= PG_4K;
      rsp_base  <= '0;
      rsp_attr  <= '0;
      rsp_entry <= '0;
      rsp_wb    <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_fault <= c_fault;
        rsp_cause <= c_cause;
        rsp_leaf  <= c_leaf;
        rsp_size  <= c_size;
        rsp_base  <= c_base;
        rsp_attr  <= c_attr;
        rsp_entry <= c_entry;
        rsp_wb    <= c_wb;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R12: a stalled result does not move
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_entry) &&
                                   $stable(rsp_cause) && $stable(rsp_base)));
  // R12: an accepted request always yields a result next cycle
  p_result_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R4: writeback is never requested for a faulting access
  p_wb_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wb) |-> !rsp_fault);
  // R11: fault flag agrees with the cause
  p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

endmodule

// File: tb/pte_check_unit_tb.sv
module pte_check_unit_tb;

  typedef struct packed {
    logic [63:0] e;
    logic [1:0]  lvl;
    logic [1:0]  acc;
    logic [1:0]  cpl;
    logic [3:0]  md;    // {wide, long, nxe, pse}
    logic [2:0]  cause;
    logic [1:0]  sz;
    logic [2:0]  attr;
    logic        wb;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [3:0] ML = 4'b1110;  // long mode, no-execute on
  localparam logic [3:0] MG = 4'b0000;  // 32-bit entries
  localparam logic [3:0] MP = 4'b1000;  // wide, not strict
  localparam logic [3:0] MS = 4'b1001;  // wide with size extension, strict

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{64'h0000_0000_0012_3003, 2'd0, 2'd0, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd4},  // R4 first touch
    '{64'h0000_0000_0012_3023, 2'd0, 2'd0, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b0, 4'd4},  // R4 already marked
    '{64'h0000_0000_0012_3023, 2'd0, 2'd1, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd5},  // R5 first write
    '{64'h0000_0000_0012_3063, 2'd0, 2'd1, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b0, 4'd5},  // R5 already dirty
    '{64'h0000_0000_0045_6003, 2'd1, 2'd1, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd5},  // R5 table pointer
    '{64'h0000_0000_0012_3001, 2'd0, 2'd1, 2'd0, ML, 3'd4, 2'd0, 3'd0, 1'b0, 4'd2},  // R2 write ro
    '{64'h0000_0000_0012_3001, 2'd0, 2'd0, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd2},  // R2 read ro
    '{64'h0000_0000_0012_3001, 2'd0, 2'd2, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd2},  // R2 fetch ro
    '{64'h0000_0000_0012_3003, 2'd0, 2'd0, 2'd3, ML, 3'd3, 2'd0, 3'd0, 1'b0, 4'd3},  // R3 user denied
    '{64'h0000_0000_0012_3003, 2'd0, 2'd0, 2'd2, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd3},  // R3 level 2 ok
    '{64'h0000_0000_0012_3007, 2'd0, 2'd0, 2'd3, ML, 3'd0, 2'd0, 3'd0, 1'b1, 4'd3},  // R3 user ok
    '{64'h8000_0000_0000_0FFE, 2'd0, 2'd1, 2'd3, ML, 3'd1, 2'd0, 3'd7, 1'b0, 4'd1},  // R1 not present
    '{64'h8000_0000_0012_3027, 2'd0, 2'd2, 2'd0, ML, 3'd5, 2'd0, 3'd0, 1'b0, 4'd6},  // R6 nx fetch
    '{64'h8000_0000_0012_3027, 2'd0, 2'd0, 2'd0, ML, 3'd0, 2'd0, 3'd0, 1'b0, 4'd6},  // R6 nx read
    '{64'h8000_0000_0012_3027, 2'd0, 2'd0, 2'd0, MP, 3'd2, 2'd0, 3'd0, 1'b0, 4'd6},  // R6 nx disabled
    '{64'h8000_0000_0012_3027, 2'd0, 2'd2, 2'd0, MG, 3'd0, 2'd0, 3'd0, 1'b0, 4'd6},  // R6 32-bit ignore
    '{64'h0000_0000_4060_10B3, 2'd1, 2'd0, 2'd0, ML, 3'd0, 2'd1, 3'd6, 1'b0, 4'd7},  // R7 R9 2 MB
    '{64'h0000_0000_4060_30A3, 2'd1, 2'd0, 2'd0, ML, 3'd2, 2'd1, 3'd4, 1'b0, 4'd10}, // R10 bit 13
    '{64'h0000_0000_4060_30A3, 2'd1, 2'd0, 2'd0, MP, 3'd0, 2'd1, 3'd4, 1'b0, 4'd10}, // R10 lax
    '{64'h0000_0000_4060_30A3, 2'd1, 2'd0, 2'd0, MS, 3'd2, 2'd1, 3'd4, 1'b0, 4'd10}, // R10 pse strict
    '{64'h0000_0000_00C0_008B, 2'd1, 2'd0, 2'd0, MG, 3'd0, 2'd2, 3'd1, 1'b1, 4'd7},  // R7 R8 4 MB
    '{64'h0000_0000_C000_0087, 2'd2, 2'd1, 2'd3, ML, 3'd0, 2'd3, 3'd0, 1'b1, 4'd7},  // R7 1 GB
    '{64'h0000_0000_C000_0087, 2'd2, 2'd1, 2'd3, MP, 3'd0, 2'd0, 3'd0, 1'b1, 4'd7},  // R7 no 1 GB
    '{64'h0000_0000_0012_30A3, 2'd0, 2'd0, 2'd0, ML, 3'd0, 2'd0, 3'd4, 1'b0, 4'd9},  // R9 pat bit 7
    '{64'h0010_0000_0012_3023, 2'd0, 2'd0, 2'd0, ML, 3'd2, 2'd0, 3'd0, 1'b0, 4'd10}, // R10 high bit
    '{64'h0010_0000_0012_3023, 2'd0, 2'd0, 2'd0, MP, 3'd0, 2'd0, 3'd0, 1'b0, 4'd8},  // R8 base width
    '{64'h0010_0000_0012_3021, 2'd0, 2'd1, 2'd3, ML, 3'd2, 2'd0, 3'd0, 1'b0, 4'd11}, // R11 rsv first
    '{64'h0000_0000_0012_3021, 2'd0, 2'd1, 2'd3, ML, 3'd3, 2'd0, 3'd0, 1'b0, 4'd11}, // R11 priv first
    '{64'h0000_0000_E000_0087, 2'd2, 2'd0, 2'd0, ML, 3'd2, 2'd3, 3'd0, 1'b0, 4'd10}  // R10 1 GB rsv
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_entry = '0;
  logic [1:0]  req_level = '0;
  logic [1:0]  req_access = '0;
  logic [1:0]  req_cpl = '0;
  logic        req_pae = 1'b0, req_long = 1'b0, req_nxe = 1'b0, req_pse = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic        rsp_leaf;
  logic [1:0]  rsp_size;
  logic [63:0] rsp_base;
  logic [2:0]  rsp_attr;
  logic [63:0] rsp_entry;
  logic        rsp_wb;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  pte_check_unit u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_entry (req_entry), .req_level (req_level), .req_access (req_access),
    .req_cpl (req_cpl), .req_pae (req_pae), .req_long (req_long),
    .req_nxe (req_nxe), .req_pse (req_pse),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_fault (rsp_fault), .rsp_cause (rsp_cause), .rsp_leaf (rsp_leaf),
    .rsp_size (rsp_size), .rsp_base (rsp_base), .rsp_attr (rsp_attr),
    .rsp_entry (rsp_entry), .rsp_wb (rsp_wb)
  );

  function automatic logic [63:0] exp_base(input vec_t v);
    int off;
    logic [63:0] b;
    off = (v.sz == 2'd1) ? 21 : (v.sz == 2'd2) ? 22 : (v.sz == 2'd3) ? 30 : 12;
    b = v.md[3] ? {12'd0, v.e[51:0]} : {32'd0, v.e[31:0]};
    return (b >> off) << off;
  endfunction

  function automatic logic exp_leaf(input vec_t v);
    return (v.lvl == 2'd0) || (v.sz != 2'd0);
  endfunction

  function automatic logic [63:0] exp_entry(input vec_t v);
    logic [63:0] r;
    r = v.e;
    if (v.cause == 3'd0) begin
      r[5] = 1'b1;
      if (v.acc == 2'd1 && exp_leaf(v)) r[6] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_entry  = v.e;
    req_level  = v.lvl;
    req_access = v.acc;
    req_cpl    = v.cpl;
    {req_pae, req_long, req_nxe, req_pse} = v.md;
  endtask

  task automatic compare(input vec_t v, input int idx);
    string tag;
    logic [63:0] eb, ee;
    bit ok;
    tag = $sformatf("R%0d vec%0d", v.rq, idx);
    eb = exp_base(v);
    ee = exp_entry(v);
    ok = rsp_valid && (rsp_cause == v.cause) && (rsp_fault == (v.cause != 3'd0)) &&
         (rsp_size == v.sz) && (rsp_attr == v.attr) && (rsp_wb == v.wb) &&
         (rsp_leaf == exp_leaf(v)) && (rsp_base == eb) && (rsp_entry == ee);
    check(ok, tag, "cause/size/attr/wb/leaf",
          {50'd0, rsp_valid, rsp_cause, rsp_size, rsp_attr, rsp_wb, rsp_leaf, rsp_fault},
          {50'd0, 1'b1, v.cause, v.sz, v.attr, v.wb, exp_leaf(v), (v.cause != 3'd0)});
    check(rsp_base == eb, tag, "base", rsp_base, eb);
    check(rsp_entry == ee, tag, "entry", rsp_entry, ee);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check(!rsp_valid && req_ready, "R13", "valid/ready in reset",
          {62'd0, rsp_valid, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R13", "valid/ready after reset",
          {62'd0, rsp_valid, req_ready}, 64'd1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      compare(VT[i], i);
    end

    // R12 idle: no result without a request
    @(negedge clk);
    @(negedge clk);
    check(!rsp_valid, "R12", "idle valid", {63'd0, rsp_valid}, 64'd0);

    // R12 stall: result held, new request waits
    rsp_ready = 1'b0;
    drive(VT[0]);
    req_valid = 1'b1;
    @(negedge clk);
    check(rsp_valid && !req_ready, "R12", "stall valid/ready",
          {62'd0, rsp_valid, req_ready}, 64'd2);
    drive(VT[2]);
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid && rsp_entry == exp_entry(VT[0]) && rsp_wb, "R12", "held entry",
          rsp_entry, exp_entry(VT[0]));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    compare(VT[2], 2);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R12", "drained",
          {62'd0, rsp_valid, req_ready}, 64'd1);

    // R12 back-to-back: ready stays high while results are consumed
    drive(VT[5]);
    req_valid = 1'b1;
    @(negedge clk);
    check(req_ready && rsp_valid, "R12", "ready with consumer",
          {62'd0, rsp_valid, req_ready}, 64'd3);
    drive(VT[8]);
    @(negedge clk);
    req_valid = 1'b0;
    compare(VT[8], 8);

    // R1: not-present with every other bit set, still no marks
    @(negedge clk);
    req_entry = 64'hFFFF_FFFF_FFFF_FFFE;
    req_level = 2'd0; req_access = 2'd1; req_cpl = 2'd0;
    {req_pae, req_long, req_nxe, req_pse} = ML;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_cause == 3'd1 && !rsp_wb && rsp_entry == 64'hFFFF_FFFF_FFFF_FFFE,
          "R1", "all-ones absent entry", {61'd0, rsp_cause}, 64'd1);

    @(negedge clk);
    finish_run();
  end

endmodule